// File: doc/BRIEF.md
# Cascadable Programmable Interval Counter

This block holds three 16-bit down-counters in the manner of a classic programmable interval timer. Every counter picks its own count source: the internal tick (a fixed division of the system clock, standing for a 10 MHz time base) or a rising edge on its own external clock pin. A small write port takes one command byte per counter, which sets the counter's byte access type and operating mode. It then takes the count bytes. Two modes are built: stop on terminal count (mode 0) and gate-triggered strobe (mode 5).

Counter 0 can be chained ahead of counter 1. The pair then forms one 32-bit timer, with counter 1 stepping once for every rising edge of counter 0's output. The outputs of counters 1 and 2 each raise a one-cycle interrupt request pulse. A combinational status port returns, for any counter, its output level, a null-count flag, its access type and its mode.

Top module: `cascade_interval_timer`

## Requirements
- R1: Each counter has a clock-select bit (`clk_sel[i]`). At 0 it steps on the internal tick. At 1 it steps on a rising edge of `ext_clk[i]`, after `SYNC_STAGES` synchronizer flops, and the internal tick has no effect on it.
- R2: While `cascade_en` is 1, counter 1 steps once per rising edge of `cnt_out[0]` and ignores its own source.
- R3: A write to address 3 is a command byte. Bits [7:6] pick the counter (0 to 2). Bits [5:4] set the access type: 01 low byte, 10 high byte, 11 low then high. Bits [3:1] set the mode: 5 is the strobe mode and any other value acts as mode 0. Bit 0 is ignored. A command with select 3 or access 00 changes nothing.
- R4: Data is written to address i for counter i. Low-byte access loads {0, byte}. High-byte access loads {byte, 0}. Low-then-high access uses a byte pointer that toggles on every data write and is cleared by a command; the load completes only on the second byte.
- R5: In mode 0 the output goes low on the command and on load completion. The count moves into the counting element on the next input step. The output goes high N input steps after that transfer and stays high until the next command or load.
- R6: In mode 5 the output is high after the command. A synchronized rising edge of `gate[i]` arms a transfer on the next input step. At terminal count the output is low for exactly one input step. A new gate edge while counting reloads the count.
- R7: A loaded count of 0 counts 65536 input steps.
- R8: `rd_status` for `rd_sel` 0 to 2 is {out, null, access[1:0], mode[2:0], 0}, and 0 for `rd_sel` 3. The null bit sets on a command and on load completion, and clears at the transfer.
- R9: `irq[0]` and `irq[1]` pulse high for one cycle when `cnt_out[1]` or `cnt_out[2]`, respectively, rises.
- R10: After reset all outputs are 0, all status bytes are 0 and no counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 to 2 counter data, 3 command |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 2 | Counter whose status is shown |
| rd_status | output | 8 | Status byte of the selected counter |
| ext_clk | input | 3 | External clock pins, one per counter |
| clk_sel | input | 3 | Per-counter source select, 1 = external |
| gate | input | 3 | Per-counter trigger inputs |
| cascade_en | input | 1 | Chain counter 0 into counter 1 |
| cnt_out | output | 3 | Counter output levels |
| irq | output | 2 | Rise pulses of counters 1 and 2 |

## Verification
The bench builds the block with `TICK_DIV` = 1 and `SYNC_STAGES` = 2. With those values the internal tick fires every cycle, so every latency is a fixed, small number of system cycles. It can therefore sweep counts 1 to 12 in mode 0 and 1 to 8 in mode 5 on all three counters, and compare exact cycle counts against closed formulas. The same settings keep the full 65536-step zero count within a short run. The cascade, external-clock and retrigger cases then run as single directed sequences.

// File: rtl/cit_pkg.sv
package cit_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       fmt;
  } cmd_t;

  localparam logic [2:0] MODE_STROBE = 3'd5;

  function automatic logic strobe_mode(input logic [2:0] m);
    return m == MODE_STROBE;
  endfunction

  function automatic logic [7:0] pack_status(input logic o, input logic n,
                                             input acc_e a, input logic [2:0] m);
    return {o, n, a, m, 1'b0};
  endfunction

endpackage

// File: rtl/cit_tick_gen.sv
module cit_tick_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == W'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == W'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/cit_edge_sync.sv
module cit_edge_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cit_counter.sv
module cit_counter
  import cit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              gate_rise,
  input  logic              cmd_wr,
  input  cmd_t              cmd,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] data,
  output logic              out,
  output logic              null_cnt,
  output acc_e              acc,
  output logic [2:0]        mode
);
  localparam int CNT_W = 2 * BYTE_W;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic last_step(input logic [CNT_W-1:0] v);
    return v == CNT_W'(1);
  endfunction

  logic [CNT_W-1:0]  cnt, hold;
  logic [BYTE_W-1:0] lo_byte;
  logic              ptr, pending, armed, running, trig;

  logic is_strobe, load_done, quiet, transfer, step, term_hit;

  assign is_strobe = strobe_mode(mode);
  assign load_done = data_wr && (acc != ACC_NONE) && (acc != ACC_LOHI || ptr);
  assign quiet     = ce && !data_wr && !cmd_wr;
  assign transfer  = quiet && (is_strobe ? (trig && armed) : pending);
  assign step      = quiet && running && !transfer;
  assign term_hit  = step && last_step(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig <= 1'b0;
    end else if (cmd_wr) begin
      trig <= 1'b0;
    end else if (gate_rise && is_strobe) begin
      trig <= 1'b1;
    end else if (transfer) begin
      trig <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; hold <= '0; lo_byte <= '0; ptr <= 1'b0;
      pending <= 1'b0; armed <= 1'b0; running <= 1'b0;
      out <= 1'b0; null_cnt <= 1'b0; acc <= ACC_NONE; mode <= '0;
    end else if (cmd_wr) begin
      acc      <= cmd.acc;
      mode     <= cmd.mode;
      out      <= strobe_mode(cmd.mode);
      null_cnt <= 1'b1;
      pending  <= 1'b0;
      armed    <= 1'b0;
      running  <= 1'b0;
      ptr      <= 1'b0;
    end else if (data_wr) begin
      unique case (acc)
        ACC_LO: hold <= {{BYTE_W{1'b0}}, data};
        ACC_HI: hold <= {data, {BYTE_W{1'b0}}};
        ACC_LOHI: begin
          if (!ptr) lo_byte <= data;
          else      hold    <= {data, lo_byte};
          ptr <= ~ptr;
        end
        default: ;
      endcase
      if (load_done) begin
        pending  <= 1'b1;
        armed    <= 1'b1;
        null_cnt <= 1'b1;
        if (!is_strobe) begin
          out     <= 1'b0;
          running <= 1'b0;
        end
      end
    end else if (transfer) begin
      cnt      <= hold;
      pending  <= 1'b0;
      null_cnt <= 1'b0;
      running  <= 1'b1;
      if (is_strobe) out <= 1'b1;
    end else if (step) begin
      cnt <= step_down(cnt);
      if (term_hit) begin
        running <= 1'b0;
        out     <= !is_strobe;
      end
    end else if (quiet && is_strobe && !out) begin
      out <= 1'b1;
    end
  end

  a_r5_cmd_mode0_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !strobe_mode(cmd.mode) |=> !out && null_cnt);
  a_r5_mode0_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    !is_strobe && out && !cmd_wr && !load_done |=> out);
  a_r6_strobe_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    is_strobe && !out && quiet |=> out);
  a_r8_load_sets_null: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && !cmd_wr |=> null_cnt);
  a_r8_transfer_clears_null: assert property (@(posedge clk) disable iff (!rst_n)
    transfer |=> !null_cnt);
endmodule

// File: rtl/cascade_interval_timer.sv
module cascade_interval_timer
  import cit_pkg::*;
#(
  parameter int TICK_DIV    = 10,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [7:0]        rd_status,
  input  logic [2:0]        ext_clk,
  input  logic [2:0]        clk_sel,
  input  logic [2:0]        gate,
  input  logic              cascade_en,
  output logic [2:0]        cnt_out,
  output logic [1:0]        irq
);
  localparam int         N_CNT    = 3;
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic             tick;
  logic [N_CNT-1:0] ext_rise, gate_rise, ce, out_q, out_rise;
  logic [N_CNT-1:0] null_v;
  acc_e             acc_v  [N_CNT];
  logic [2:0]       mode_v [N_CNT];
  cmd_t             cmd;
  logic             cmd_ok;

  cit_tick_gen #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  cit_edge_sync #(.WIDTH(N_CNT), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise));

  cit_edge_sync #(.WIDTH(N_CNT), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate), .rise(gate_rise));

  assign cmd    = cmd_t'(wr_data[7:0]);
  assign cmd_ok = wr_en && (wr_addr == CMD_ADDR) && (cmd.sel != 2'd3) && (cmd.acc != ACC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= cnt_out;
  end
  assign out_rise = cnt_out & ~out_q;
  assign irq      = out_rise[2:1];

  generate
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
      logic own_src;
      assign own_src = clk_sel[i] ? ext_rise[i] : tick;
      if (i == 1) begin : g_chain
        assign ce[i] = cascade_en ? out_rise[0] : own_src;
      end else begin : g_solo
        assign ce[i] = own_src;
      end

      cit_counter #(.BYTE_W(BYTE_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce[i]),
        .gate_rise(gate_rise[i]),
        .cmd_wr   (cmd_ok && (cmd.sel == 2'(i))),
        .cmd      (cmd),
        .data_wr  (wr_en && (wr_addr == 2'(i))),
        .data     (wr_data),
        .out      (cnt_out[i]),
        .null_cnt (null_v[i]),
        .acc      (acc_v[i]),
        .mode     (mode_v[i])
      );
    end
  endgenerate

  always_comb begin
    rd_status = '0;
    for (int k = 0; k < N_CNT; k++)
      if (rd_sel == 2'(k)) rd_status = pack_status(cnt_out[k], null_v[k], acc_v[k], mode_v[k]);
  end

  a_r9_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |=> !irq[0]);
  a_r9_irq2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |=> !irq[1]);
endmodule

// File: tb/tb_cascade_interval_timer.sv
module tb_cascade_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_status;
  logic [2:0] ext_clk = '0;
  logic [2:0] clk_sel = '0;
  logic [2:0] gate = '0;
  logic       cascade_en = 1'b0;
  logic [2:0] cnt_out;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cascade_interval_timer #(.TICK_DIV(1), .SYNC_STAGES(2), .BYTE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_status(rd_status), .ext_clk(ext_clk), .clk_sel(clk_sel),
    .gate(gate), .cascade_en(cascade_en), .cnt_out(cnt_out), .irq(irq));

  function automatic logic [7:0] cmd_byte(input int sel, input int acc, input int mode);
    return {sel[1:0], acc[1:0], mode[2:0], 1'b0};
  endfunction

  function automatic logic [7:0] status_of(input logic o, input logic n, input int acc, input int mode);
    return {o, n, acc[1:0], mode[2:0], 1'b0};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_out(input int idx, input logic lvl, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (cnt_out[idx] == lvl) break;
    end
  endtask

  task automatic status(input int idx, output logic [7:0] s);
    rd_sel = idx[1:0];
    #1 s = rd_status;
  endtask

  task automatic ext_pulse(input int idx);
    ext_clk[idx] = 1'b1; idle(3);
    ext_clk[idx] = 1'b0; idle(3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected below 190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [7:0] s;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    check("R10 outputs", {cnt_out, irq}, 0);
    for (int i = 0; i < 4; i++) begin
      status(i, s);
      check("R10 status", s, 0);
    end

    // R5 / R8 mode 0 sweep on every counter, low-byte access
    for (int i = 0; i < 3; i++) begin
      for (int c = 1; c <= 12; c++) begin
        wr(3, cmd_byte(i, 1, 0));
        check("R5 low after command", cnt_out[i], 0);
        wr(i, 8'(c));
        status(i, s);
        check("R8 null after load", s, status_of(1'b0, 1'b1, 1, 0));
        wait_out(i, 1'b1, 100, n);
        check("R5 mode0 delay", n, c + 1);
        status(i, s);
        check("R8 status after transfer", s, status_of(1'b1, 1'b0, 1, 0));
        idle(3);
        check("R5 stays high", cnt_out[i], 1);
      end
    end

    // R9 interrupt pulse from counter 2
    wr(3, cmd_byte(2, 1, 0));
    wr(2, 8'd2);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq[1]) n++;
    end
    check("R9 irq from counter 2 pulse count", n, 1);

    // R3 ignored commands: select 3 and access 00 leave counter 0 high
    wr(3, cmd_byte(0, 1, 0));
    wr(0, 8'd1);
    idle(5);
    wr(3, cmd_byte(3, 1, 0));
    wr(3, cmd_byte(0, 0, 0));
    idle(2);
    status(0, s);
    check("R3 ignored commands", s, status_of(1'b1, 1'b0, 1, 0));

    // R4 low then high access
    wr(3, cmd_byte(0, 3, 0));
    wr(0, 8'h34);
    idle(5);
    check("R4 first byte does not load", cnt_out[0], 0);
    wr(0, 8'h01);
    wait_out(0, 1'b1, 1000, n);
    check("R4 low then high count", n, 16'h0134 + 1);

    // R4 high byte only
    wr(3, cmd_byte(1, 2, 0));
    wr(1, 8'h01);
    wait_out(1, 1'b1, 1000, n);
    check("R4 high byte count", n, 256 + 1);

    // R6 mode 5 sweep on every counter
    for (int i = 0; i < 3; i++) begin
      for (int c = 1; c <= 8; c++) begin
        wr(3, cmd_byte(i, 1, 5));
        check("R6 high after command", cnt_out[i], 1);
        wr(i, 8'(c));
        idle(4);
        check("R6 no count without trigger", cnt_out[i], 1);
        gate[i] = 1'b1;
        wait_out(i, 1'b0, 100, n);
        check("R6 strobe delay", n, c + 4);
        @(negedge clk);
        check("R6 strobe width", cnt_out[i], 1);
        gate[i] = 1'b0;
        idle(3);
      end
    end

    // R6 retrigger restarts the count
    wr(3, cmd_byte(0, 1, 5));
    wr(0, 8'd10);
    gate[0] = 1'b1;
    n = 0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); if (!cnt_out[0]) n++; end
    gate[0] = 1'b0;
    for (int k = 0; k < 2; k++) begin @(negedge clk); if (!cnt_out[0]) n++; end
    check("R6 no strobe before retrigger", n, 0);
    gate[0] = 1'b1;
    wait_out(0, 1'b0, 100, n);
    check("R6 retrigger delay", n, 10 + 4);
    gate[0] = 1'b0;
    idle(3);

    // R1 external clock on counter 2
    clk_sel = 3'b100;
    wr(3, cmd_byte(2, 1, 0));
    wr(2, 8'd3);
    idle(10);
    check("R1 internal tick ignored", cnt_out[2], 0);
    for (int p = 1; p <= 3; p++) ext_pulse(2);
    check("R1 low after three edges", cnt_out[2], 0);
    ext_pulse(2);
    check("R1 high after four edges", cnt_out[2], 1);
    clk_sel = 3'b000;

    // R2 cascade: counter 1 steps on counter 0 strobe ends
    cascade_en = 1'b1;
    wr(3, cmd_byte(1, 1, 0));
    wr(1, 8'd2);
    wr(3, cmd_byte(0, 1, 5));
    wr(0, 8'd1);
    idle(10);
    check("R2 counter 1 waits for counter 0", cnt_out[1], 0);
    for (int p = 1; p <= 2; p++) begin
      gate[0] = 1'b1; idle(3); gate[0] = 1'b0; idle(9);
    end
    check("R2 low after two cascade edges", cnt_out[1], 0);
    gate[0] = 1'b1;
    n = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (irq[0]) n++;
      if (k == 2) gate[0] = 1'b0;
    end
    check("R2 high after three cascade edges", cnt_out[1], 1);
    check("R9 irq from counter 1 pulse count", n, 1);
    cascade_en = 1'b0;

    // R7 zero count is 65536
    wr(3, cmd_byte(2, 1, 0));
    wr(2, 8'd0);
    wait_out(2, 1'b1, 70000, n);
    check("R7 zero count", n, 65536 + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule